// File: doc/BRIEF.md
# Indexed Endpoint FIFO Access Window

This block gives a processor access to the packet buffers of up to seven USB endpoints through a small register file. A select register picks the active endpoint. A single data register then either pops bytes from that endpoint's receive buffer or pushes bytes into its transmit buffer. Each access moves a pointer that belongs to that endpoint, so software never handles addresses.

The USB side is reduced to two simple ports. A byte-strobe delivery port fills the receive buffers. When the last byte of a packet arrives, it loads that endpoint's byte count. A drain port lets the transmit engine read transmit bytes by index and clear an endpoint's transmit pointer once the data has been sent. The byte count only changes when a packet arrives. Processor reads and writes of the data register leave it unchanged, so software should sample it before emptying the buffer. Bulk and interrupt endpoints use exactly the same path.

Top module: `ep_fifo_window`

## Requirements
- R1: After reset, the selection is endpoint 0, every byte count is 0, every overflow flag is 0, and `cpu_rdata` is 0.
- R2: Register addresses are decoded as follows:
  - Address 0 is the selection. Bits 2:0 are writable and read back zero-extended.
  - Address 1 is data.
  - Address 2 is the count low byte and address 3 is the count high byte, both for the selected endpoint.
  - Address 4 holds the overflow flags, with bit e belonging to endpoint e.
  - Any other address reads 0.
  - Read data appears on `cpu_rdata` one cycle after `cpu_rd`. `cpu_rdata` is 0 in any cycle that does not follow a read.
- R3: A data read returns the receive byte at the selected endpoint's read pointer. The pointer then advances by one, modulo DEPTH, in time for a read in the very next cycle.
- R4: A data write stores the byte at the selected endpoint's transmit write pointer and advances that pointer by one.
- R5: When a packet's last byte is delivered, the endpoint's count becomes the number of bytes in the packet, capped at DEPTH. Bytes beyond DEPTH are dropped, and the endpoint's read pointer returns to 0.
- R6: The byte count is not changed by data reads, by data writes, or by writes to addresses 2 and 3.
- R7: Each endpoint keeps its own read and write pointers. Selecting another endpoint and then coming back resumes at the saved positions.
- R8: A data write to an endpoint whose write pointer equals DEPTH is discarded, and that endpoint's overflow flag is set. The flag stays set until that endpoint is drained.
- R9: `drain_clr` with a valid `drain_ep` resets that endpoint's write pointer to 0 and clears its overflow flag.
- R10: With selection value 7:
  - data reads return 0x00 and move no pointer;
  - data writes change no buffer, pointer or flag;
  - count reads return 0.
- R11: `drain_data` holds the transmit byte at (`drain_ep`, `drain_idx`) one cycle after those inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data |
| pkt_stb | input | 1 | Received byte valid |
| pkt_ep | input | 3 | Endpoint of received byte |
| pkt_byte | input | 8 | Received byte |
| pkt_last | input | 1 | Byte is the last of its packet |
| drain_clr | input | 1 | Reset transmit pointer of `drain_ep` |
| drain_ep | input | 3 | Endpoint for drain read and clear |
| drain_idx | input | $clog2(DEPTH) | Byte index for drain read |
| drain_data | output | 8 | Registered transmit byte |

## Verification
The bench builds the block with seven endpoints and DEPTH = 256. With that depth, a full packet reports a count of 256, which puts a 1 in the count high byte. It also lets a 300-byte packet show the cap, and 257 writes to one endpoint push it into overflow while keeping the run short. Random packets, selections, reads, writes and drains are compared against a per-endpoint model of contents, pointers, counts and flags. Directed cases cover the null selection and pointer resume.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int EP_W = 3;
  typedef enum logic [2:0] {
    REG_SEL  = 3'd0,
    REG_DATA = 3'd1,
    REG_CNTL = 3'd2,
    REG_CNTH = 3'd3,
    REG_OVF  = 3'd4
  } reg_e;
endpackage

// File: rtl/epw_rx_store.sv
// Receive buffers for all endpoints plus per-endpoint packet byte counts.
module epw_rx_store #(
  parameter int NUM_EP = 7,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pkt_stb,
  input  logic [2:0]           pkt_ep,
  input  logic [7:0]           pkt_byte,
  input  logic                 pkt_last,
  input  logic [2:0]           rd_ep,
  input  logic [AW-1:0]        rd_idx,
  output logic [7:0]           rd_byte,
  output logic [NUM_EP*CW-1:0] cnt_flat,
  output logic [NUM_EP-1:0]    done_hot
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [7:0]    mem [NUM_EP*DEPTH];
  logic [CW-1:0] fill_q [NUM_EP];
  logic [CW-1:0] cnt_q  [NUM_EP];
  logic [NUM_EP-1:0] hit_hot;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign hit_hot[e]  = pkt_stb && (pkt_ep == 3'(e));
    assign done_hot[e] = hit_hot[e] && pkt_last;
    assign cnt_flat[e*CW +: CW] = cnt_q[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_EP; e++) begin
        fill_q[e] <= '0;
        cnt_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (hit_hot[e]) begin
          if (pkt_last) begin
            fill_q[e] <= '0;
            cnt_q[e]  <= (fill_q[e] < DEPTH_C) ? fill_q[e] + ONE_C : DEPTH_C;
          end else if (fill_q[e] < DEPTH_C) begin
            fill_q[e] <= fill_q[e] + ONE_C;
          end
        end
      end
    end
  end

  // Storage: one write port (USB side), one registered read port (CPU side).
  always_ff @(posedge clk) begin
    if ((|hit_hot) && fill_q[pkt_ep] < DEPTH_C)
      mem[{pkt_ep, fill_q[pkt_ep][AW-1:0]}] <= pkt_byte;
    rd_byte <= mem[{rd_ep, rd_idx}];
  end

  logic cnt_over;
  always_comb begin
    cnt_over = 1'b0;
    for (int e = 0; e < NUM_EP; e++)
      if (cnt_q[e] > DEPTH_C) cnt_over = 1'b1;
  end

  a_r5_cnt_cap: assert property (@(posedge clk) disable iff (rst) !cnt_over)
    else $error("R5: byte count above DEPTH");
endmodule

// File: rtl/epw_tx_store.sv
// Transmit buffers for all endpoints with write pointers and overflow flags.
module epw_tx_store #(
  parameter int NUM_EP = 7,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [2:0]        wr_ep,
  input  logic [7:0]        wr_byte,
  input  logic              clr_stb,
  input  logic [2:0]        clr_ep,
  input  logic [2:0]        rd_ep,
  input  logic [AW-1:0]     rd_idx,
  output logic [7:0]        rd_byte,
  output logic [NUM_EP-1:0] ovf
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [7:0]        mem [NUM_EP*DEPTH];
  logic [CW-1:0]     wptr_q [NUM_EP];
  logic [NUM_EP-1:0] wr_hot, clr_hot, full_hot;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign wr_hot[e]   = wr_stb  && (wr_ep  == 3'(e));
    assign clr_hot[e]  = clr_stb && (clr_ep == 3'(e));
    assign full_hot[e] = (wptr_q[e] == DEPTH_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= '0;
      for (int e = 0; e < NUM_EP; e++) wptr_q[e] <= '0;
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (clr_hot[e]) begin
          wptr_q[e] <= '0;
          ovf[e]    <= 1'b0;
        end else if (wr_hot[e]) begin
          if (full_hot[e]) ovf[e] <= 1'b1;
          else             wptr_q[e] <= wptr_q[e] + ONE_C;
        end
      end
    end
  end

  logic mem_we;
  assign mem_we = (|(wr_hot & ~clr_hot & ~full_hot));

  always_ff @(posedge clk) begin
    if (mem_we) mem[{wr_ep, wptr_q[wr_ep][AW-1:0]}] <= wr_byte;
    rd_byte <= mem[{rd_ep, rd_idx}];
  end

  logic wptr_over;
  always_comb begin
    wptr_over = 1'b0;
    for (int e = 0; e < NUM_EP; e++)
      if (wptr_q[e] > DEPTH_C) wptr_over = 1'b1;
  end

  a_r8_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (|(wr_hot & full_hot & ~clr_hot)) |=> ((ovf & $past(wr_hot)) == $past(wr_hot)))
    else $error("R8: overflow flag not set");
  a_r8_wptr_bound: assert property (@(posedge clk) disable iff (rst) !wptr_over)
    else $error("R8: write pointer above DEPTH");
  a_r9_clr_flag: assert property (@(posedge clk) disable iff (rst)
    (|clr_hot) |=> ((ovf & $past(clr_hot)) == '0))
    else $error("R9: overflow flag survived drain");
endmodule

// File: rtl/ep_fifo_window.sv
// CPU register window: endpoint select, data port and count readout.
module ep_fifo_window
  import epw_pkg::*;
#(
  parameter int NUM_EP = 7,   // at most 7; selection value 7 is always empty
  parameter int DEPTH  = 64   // power of two, at most 32768
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [2:0]               cpu_addr,
  input  logic [7:0]               cpu_wdata,
  output logic [7:0]               cpu_rdata,
  input  logic                     pkt_stb,
  input  logic [2:0]               pkt_ep,
  input  logic [7:0]               pkt_byte,
  input  logic                     pkt_last,
  input  logic                     drain_clr,
  input  logic [2:0]               drain_ep,
  input  logic [$clog2(DEPTH)-1:0] drain_idx,
  output logic [7:0]               drain_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0]    NEP_C = 3'(NUM_EP);
  localparam logic [AW-1:0] STEP_C = AW'(1);

  logic [2:0]           sel_q, sel_ix, drain_ix;
  logic                 sel_ok, drain_ok;
  logic [AW-1:0]        rptr_q [NUM_EP];
  logic [AW-1:0]        cur_rptr;
  logic [NUM_EP-1:0]    done_hot, ovf, rptr_zero;
  logic [NUM_EP*CW-1:0] cnt_flat;
  logic [15:0]          cnt16;
  logic [7:0]           rx_byte, reg_mux, reg_q;
  logic                 data_q, rd_hit, wr_hit;

  assign sel_ok   = sel_q < NEP_C;
  assign sel_ix   = sel_ok ? sel_q : 3'd0;
  assign drain_ok = drain_ep < NEP_C;
  assign drain_ix = drain_ok ? drain_ep : 3'd0;
  assign cur_rptr = rptr_q[sel_ix];
  assign rd_hit   = cpu_rd && cpu_addr == REG_DATA && sel_ok;
  assign wr_hit   = cpu_wr && cpu_addr == REG_DATA && sel_ok;
  assign cnt16    = 16'(cnt_flat[sel_ix*CW +: CW]);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_zero
    assign rptr_zero[e] = (rptr_q[e] == '0);
  end

  always_comb begin
    case (cpu_addr)
      REG_SEL:  reg_mux = {5'd0, sel_q};
      REG_CNTL: reg_mux = sel_ok ? cnt16[7:0]  : 8'h00;
      REG_CNTH: reg_mux = sel_ok ? cnt16[15:8] : 8'h00;
      REG_OVF:  reg_mux = 8'(ovf);
      default:  reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 3'd0;
      data_q <= 1'b0;
      reg_q  <= 8'h00;
      for (int e = 0; e < NUM_EP; e++) rptr_q[e] <= '0;
    end else begin
      if (cpu_wr && cpu_addr == REG_SEL) sel_q <= cpu_wdata[2:0];
      for (int e = 0; e < NUM_EP; e++) begin
        if (done_hot[e])                          rptr_q[e] <= '0;
        else if (rd_hit && sel_ix == 3'(e))       rptr_q[e] <= rptr_q[e] + STEP_C;
      end
      data_q <= rd_hit;
      reg_q  <= (cpu_rd && cpu_addr != REG_DATA) ? reg_mux : 8'h00;
    end
  end

  assign cpu_rdata = data_q ? rx_byte : reg_q;

  epw_rx_store #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst),
    .pkt_stb(pkt_stb), .pkt_ep(pkt_ep), .pkt_byte(pkt_byte), .pkt_last(pkt_last),
    .rd_ep(sel_ix), .rd_idx(cur_rptr), .rd_byte(rx_byte),
    .cnt_flat(cnt_flat), .done_hot(done_hot)
  );

  epw_tx_store #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst),
    .wr_stb(wr_hit), .wr_ep(sel_ix), .wr_byte(cpu_wdata),
    .clr_stb(drain_clr && drain_ok), .clr_ep(drain_ix),
    .rd_ep(drain_ix), .rd_idx(drain_idx), .rd_byte(drain_data),
    .ovf(ovf)
  );

  a_r3_rptr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !cpu_wr && !done_hot[sel_ix]) |=> (cur_rptr == $past(cur_rptr) + STEP_C))
    else $error("R3: read pointer did not advance");
  a_r5_rptr_restart: assert property (@(posedge clk) disable iff (rst)
    (|done_hot) |=> ((rptr_zero & $past(done_hot)) == $past(done_hot)))
    else $error("R5: read pointer not restarted");
  a_r6_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
    !(pkt_stb && pkt_last) |=> $stable(cnt_flat))
    else $error("R6: count moved without packet end");
  a_r10_null_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == REG_DATA && sel_q == 3'd7) |=> (cpu_rdata == 8'h00))
    else $error("R10: null selection returned data");
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == 8'h00))
    else $error("R2: read data nonzero without read");
endmodule

// File: tb/ep_fifo_window_tb.sv
module ep_fifo_window_tb;
  localparam int NEP = 7;
  localparam int DEPTH = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [2:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic pkt_stb = 0, pkt_last = 0;
  logic [2:0] pkt_ep = 0;
  logic [7:0] pkt_byte = 0;
  logic drain_clr = 0;
  logic [2:0] drain_ep = 0;
  logic [7:0] drain_idx = 0;
  logic [7:0] drain_data;

  always #10 clk = ~clk;

  ep_fifo_window #(.NUM_EP(NEP), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pkt_stb(pkt_stb), .pkt_ep(pkt_ep),
    .pkt_byte(pkt_byte), .pkt_last(pkt_last), .drain_clr(drain_clr), .drain_ep(drain_ep),
    .drain_idx(drain_idx), .drain_data(drain_data));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] rxm [NEP][DEPTH];
  logic [7:0] txm [NEP][DEPTH];
  int cntm [NEP], rpm [NEP], wpm [NEP];
  logic [6:0] ovfm = 0;
  int selm = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
    if (a == 3'd0) selm = int'(d[2:0]);
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  function automatic int exp_data();
    return (selm < NEP) ? int'(rxm[selm][rpm[selm]]) : 0;
  endfunction

  task automatic data_read(string req);
    logic [7:0] v;
    int e;
    e = exp_data();
    reg_rd(3'd1, v);
    chk(req, v, e);
    if (selm < NEP) rpm[selm] = (rpm[selm] + 1) % DEPTH;
  endtask

  task automatic data_write(input logic [7:0] b);
    reg_wr(3'd1, b);
    if (selm < NEP) begin
      if (wpm[selm] == DEPTH) ovfm[selm] = 1'b1;
      else begin txm[selm][wpm[selm]] = b; wpm[selm]++; end
    end
  endtask

  task automatic count_check(string req);
    logic [7:0] lo, hi;
    reg_rd(3'd2, lo);
    reg_rd(3'd3, hi);
    chk({req, " lo"}, lo, (selm < NEP) ? (cntm[selm] & 255) : 0);
    chk({req, " hi"}, hi, (selm < NEP) ? (cntm[selm] >> 8) : 0);
  endtask

  task automatic send_pkt(int ep, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pkt_stb = 1; pkt_ep = 3'(ep); pkt_byte = 8'($urandom); pkt_last = (i == len - 1);
      if (i < DEPTH) rxm[ep][i] = pkt_byte;
    end
    @(negedge clk); pkt_stb = 0; pkt_last = 0;
    cntm[ep] = (len < DEPTH) ? len : DEPTH;
    rpm[ep] = 0;
  endtask

  task automatic drain_check(string req, int ep, int idx);
    @(negedge clk); drain_ep = 3'(ep); drain_idx = 8'(idx);
    @(negedge clk);
    chk(req, drain_data, txm[ep][idx]);
  endtask

  task automatic drain_reset(int ep);
    @(negedge clk); drain_clr = 1; drain_ep = 3'(ep);
    @(negedge clk); drain_clr = 0;
    wpm[ep] = 0; ovfm[ep] = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v, b;
    void'($urandom(32'd1234));
    for (int e = 0; e < NEP; e++) begin cntm[e] = 0; rpm[e] = 0; wpm[e] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk); chk("R1 idle rdata", cpu_rdata, 0);
    reg_rd(3'd0, v); chk("R1 selection", v, 0);
    reg_rd(3'd2, v); chk("R1 count", v, 0);
    reg_rd(3'd4, v); chk("R1 overflow", v, 0);
    // R2 map
    reg_wr(3'd0, 8'hfa); reg_rd(3'd0, v); chk("R2 select readback", v, 2);
    reg_rd(3'd5, v); chk("R2 unused address", v, 0);
    @(negedge clk); chk("R2 no read zero", cpu_rdata, 0);
    // R5 / R3 / R6
    send_pkt(2, 5);
    count_check("R5 count after packet");
    for (int i = 0; i < 3; i++) data_read("R3 data read");
    count_check("R6 count after reads");
    reg_wr(3'd2, 8'hff); reg_wr(3'd3, 8'hff);
    count_check("R6 count after register write");
    // R7 resume
    reg_wr(3'd0, 8'd3); send_pkt(3, 4); data_read("R7 other endpoint");
    reg_wr(3'd0, 8'd2);
    for (int i = 0; i < 2; i++) data_read("R7 resumed read");
    reg_wr(3'd0, 8'd3); data_read("R7 resumed other");
    // R5 restart
    reg_wr(3'd0, 8'd2); send_pkt(2, 3); data_read("R5 read pointer restart");
    // R4 / R11 / R6
    reg_wr(3'd0, 8'd1);
    for (int i = 0; i < 10; i++) data_write(8'($urandom));
    for (int i = 0; i < 10; i++) drain_check("R4 R11 drain byte", 1, i);
    count_check("R6 count after writes");
    // R8 / R9
    reg_wr(3'd0, 8'd4);
    for (int i = 0; i <= DEPTH; i++) data_write(8'($urandom));
    reg_rd(3'd4, v); chk("R8 overflow flag", v, 8'h10);
    drain_check("R8 last byte kept", 4, DEPTH - 1);
    drain_reset(4);
    reg_rd(3'd4, v); chk("R9 flag cleared", v, 0);
    data_write(8'h5c); drain_check("R9 write restarts at 0", 4, 0);
    // R10 null selection
    reg_wr(3'd0, 8'd7);
    data_read("R10 null data read");
    count_check("R10 null count");
    data_write(8'hee);
    reg_rd(3'd4, v); chk("R10 flags untouched", v, 0);
    reg_wr(3'd0, 8'd0); data_write(8'h3b); drain_check("R10 endpoint 0 untouched", 0, 0);
    // R5 high byte and cap
    send_pkt(6, 256); reg_wr(3'd0, 8'd6); count_check("R5 full packet");
    send_pkt(5, 300); reg_wr(3'd0, 8'd5); count_check("R5 capped packet");
    data_read("R5 capped first byte");
    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: send_pkt($urandom_range(0, NEP - 1), $urandom_range(1, 24));
        1: reg_wr(3'd0, 8'($urandom_range(0, 7)));
        2, 3: if (selm == 7 || rpm[selm] < cntm[selm]) data_read("R3 random read");
        4: data_write(8'($urandom));
        5: count_check("R6 random count");
        6: if ($urandom_range(0, 3) == 0) drain_reset($urandom_range(0, NEP - 1));
        default: begin
          int e;
          e = $urandom_range(0, NEP - 1);
          if (wpm[e] > 0) drain_check("R11 random drain", e, $urandom_range(0, wpm[e] - 1));
          reg_rd(3'd4, b); chk("R8 random flags", b, {1'b0, ovfm});
        end
      endcase
    end
    summary();
  end
endmodule